// File: doc/BRIEF.md
# Continuation-Bit Host Command Decoder

This block sits behind a host serial receiver and turns its byte stream into decoded commands. Each byte carries seven payload bits and a continuation flag in bit 7. A set flag means the next byte belongs to the same message, and a clear flag closes the message. The decoder gathers the bytes of a message, works out what the message is from its first byte and its length, and fires a single-cycle pulse for that command. The fields of the command are presented alongside the pulse. Multi-byte values are joined with the earliest byte supplying the most significant bits.

The commands it recognises are: track power on, track power off, panic acknowledge, host link error report, point fire with a 10-bit target, ping with a 10-bit tag, polarity update with a left-aligned segment bitmap, and a raw packet-data payload. A ping is answered on the transmit side with a two-byte pong that uses the same encoding and carries the same tag. Anything malformed produces a one-cycle protocol error, and the message is dropped. A malformed message is an unknown opcode, a wrong length, an over-long message, or a ping that arrives while the previous pong is still queued.

The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `cmdstream_decoder`

## Requirements
- R1: Bit 7 of each received byte set means another byte follows. A received byte with bit 7 clear ends the message. The command pulse for the message appears in the cycle after the clock edge that accepted its final byte.
- R2: Single-byte messages decode as follows: 0x21 pulses pwr_on, 0x20 pulses pwr_off, 0x00 pulses panic_ack and 0x01 pulses host_link_err. Every other single byte pulses proto_err.
- R3: A two-byte message whose first byte has bits 6:3 equal to 0100 pulses point_fire. point_target is set to {first[2:0], second[6:0]}.
- R4: A two-byte message whose first byte has bits 6:3 equal to 0001 pulses ping_seen. ping_tag is set to {first[2:0], second[6:0]}.
- R5: An accepted ping queues a pong of two bytes on tx_data: first {1, 0001, tag[9:7]}, then {0, tag[6:0]}. Each byte is held unchanged while tx_valid is high and tx_ready is low.
- R6: A ping that ends while tx_valid is high pulses proto_err instead of ping_seen. The queued pong is left unchanged, and exactly two pong bytes are sent.
- R7: A message of two or more bytes whose first byte has bits 6:3 equal to 0010 pulses pol_set. The bitmap is built from first[2:0] followed by bits 6:0 of each later byte. pol_map[POL_W-1] holds the first bit of that bitmap. Positions beyond the bits received read zero, and bits beyond POL_W are dropped.
- R8: A message whose first byte is 0xFF pulses pkt_valid. pkt_data holds bits 6:0 of every byte in order, left-aligned, and pkt_bits is 7 times the byte count.
- R9: A point or ping message whose length is not two bytes pulses proto_err. Any message longer than MAX_BYTES bytes also pulses proto_err. In both cases no other pulse fires.
- R10: A multi-byte message is unknown if its first byte is not 0xFF and its bits 6:3 are not 0100, 0001 or 0010. An unknown message pulses proto_err.
- R11: Each message produces at most one pulse, and the pulse lasts one cycle. The field outputs hold their values until the same command is decoded again.
- R12: During and after reset, all pulses and tx_valid are low and all field outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | rx_data is valid this cycle |
| tx_ready | input | 1 | Transmitter accepts tx_data |
| tx_data | output | 8 | Pong byte to send |
| tx_valid | output | 1 | tx_data is valid |
| pwr_on | output | 1 | Power-on command pulse |
| pwr_off | output | 1 | Power-off command pulse |
| panic_ack | output | 1 | Panic acknowledge pulse |
| host_link_err | output | 1 | Host reports serial link error |
| point_fire | output | 1 | Point fire pulse |
| point_target | output | 10 | Point target |
| ping_seen | output | 1 | Ping accepted pulse |
| ping_tag | output | 10 | Ping tag |
| pol_set | output | 1 | Polarity update pulse |
| pol_map | output | POL_W | Left-aligned segment bitmap |
| pkt_valid | output | 1 | Packet data pulse |
| pkt_data | output | 7*MAX_BYTES | Left-aligned packet bits |
| pkt_bits | output | clog2(7*MAX_BYTES+1) | Number of valid packet bits |
| proto_err | output | 1 | Protocol error pulse |

## Verification
The bench builds the block with MAX_BYTES = 4 and POL_W = 12. With a 28-bit accumulator, the over-length path is reached by a five-byte message. The bench sweeps all 128 single bytes and all 128 multi-byte first bytes. It also sweeps all 1024 point targets. With a 12-bit map, two-byte polarity messages (10 bits) exercise zero fill, and three- or four-byte messages (17 and 24 bits) exercise truncation.

// File: rtl/cmd_pkg.sv
package cmd_pkg;

  typedef enum logic [3:0] {
    K_NONE,
    K_ON,
    K_OFF,
    K_ACK,
    K_SERR,
    K_POINT,
    K_PING,
    K_POL,
    K_PKT,
    K_ERR
  } msg_kind_e;

  localparam logic [7:0] BYTE_ON    = 8'h21;
  localparam logic [7:0] BYTE_OFF   = 8'h20;
  localparam logic [7:0] BYTE_ACK   = 8'h00;
  localparam logic [7:0] BYTE_SERR  = 8'h01;
  localparam logic [7:0] BYTE_PKT   = 8'hFF;

  localparam logic [3:0] OPC_POINT  = 4'b0100;
  localparam logic [3:0] OPC_PING   = 4'b0001;
  localparam logic [3:0] OPC_POL    = 4'b0010;

endpackage

// File: rtl/cmd_framer.sv
module cmd_framer #(
  parameter int MAX_BYTES = 15,
  localparam int ACC_W = 7 * MAX_BYTES,
  localparam int CW    = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       rx_data,
  input  logic             rx_valid,
  output logic             msg_end,
  output logic [7:0]       first_now,
  output logic [CW-1:0]    n_now,
  output logic [ACC_W-1:0] acc_now,
  output logic             ovf_now
);

  logic             in_msg_q, in_msg_d;
  logic [7:0]       first_q, first_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             ovf_q, ovf_d;

  // View of the message including the byte on rx_data this cycle
  always_comb begin
    msg_end = rx_valid & ~rx_data[7];
    if (!in_msg_q) begin
      first_now = rx_data;
      n_now     = CW'(1);
      ovf_now   = 1'b0;
      acc_now   = {{(ACC_W-7){1'b0}}, rx_data[6:0]};
    end else begin
      first_now = first_q;
      ovf_now   = ovf_q | (cnt_q == CW'(MAX_BYTES));
      n_now     = (cnt_q == CW'(MAX_BYTES)) ? cnt_q : cnt_q + CW'(1);
      acc_now   = {acc_q[ACC_W-8:0], rx_data[6:0]};
    end
  end

  always_comb begin
    in_msg_d = in_msg_q;
    first_d  = first_q;
    cnt_d    = cnt_q;
    acc_d    = acc_q;
    ovf_d    = ovf_q;
    if (rx_valid) begin
      if (rx_data[7]) begin
        in_msg_d = 1'b1;
        first_d  = first_now;
        cnt_d    = n_now;
        acc_d    = acc_now;
        ovf_d    = ovf_now;
      end else begin
        in_msg_d = 1'b0;
        cnt_d    = '0;
        ovf_d    = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_msg_q <= 1'b0;
      first_q  <= '0;
      cnt_q    <= '0;
      acc_q    <= '0;
      ovf_q    <= 1'b0;
    end else if (rx_valid) begin
      in_msg_q <= in_msg_d;
      first_q  <= first_d;
      cnt_q    <= cnt_d;
      acc_q    <= acc_d;
      ovf_q    <= ovf_d;
    end
  end

  // R1
  cont_opens_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_data[7]) |=> in_msg_q);

  // R1
  stop_closes_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_data[7]) |=> !in_msg_q);

endmodule

// File: rtl/cmd_classify.sv
module cmd_classify
  import cmd_pkg::*;
#(
  parameter int MAX_BYTES = 15,
  parameter int POL_W     = 17,
  localparam int ACC_W = 7 * MAX_BYTES,
  localparam int CW    = $clog2(MAX_BYTES + 1),
  localparam int BW    = $clog2(ACC_W + 1),
  localparam int SW    = BW + 1
) (
  input  logic [7:0]       first_now,
  input  logic [CW-1:0]    n_now,
  input  logic [ACC_W-1:0] acc_now,
  input  logic             ovf_now,
  output msg_kind_e        kind,
  output logic [9:0]       value10,
  output logic [POL_W-1:0] pol_map,
  output logic [ACC_W-1:0] pkt_data,
  output logic [BW-1:0]    pkt_bits
);

  logic [SW-1:0]    all_bits;
  logic [SW-1:0]    pol_bits;
  logic [ACC_W-1:0] pol_sh;

  always_comb begin
    if (n_now == CW'(1)) begin
      unique case (first_now)
        BYTE_ON:   kind = K_ON;
        BYTE_OFF:  kind = K_OFF;
        BYTE_ACK:  kind = K_ACK;
        BYTE_SERR: kind = K_SERR;
        default:   kind = K_ERR;
      endcase
    end else if (ovf_now) begin
      kind = K_ERR;
    end else if (first_now == BYTE_PKT) begin
      kind = K_PKT;
    end else begin
      unique case (first_now[6:3])
        OPC_POINT: kind = (n_now == CW'(2)) ? K_POINT : K_ERR;
        OPC_PING:  kind = (n_now == CW'(2)) ? K_PING  : K_ERR;
        OPC_POL:   kind = K_POL;
        default:   kind = K_ERR;
      endcase
    end
  end

  // Field extraction: everything is left-aligned by a variable shift
  always_comb begin
    value10  = {first_now[2:0], acc_now[6:0]};
    all_bits = SW'(n_now) * SW'(7);
    pol_bits = all_bits - SW'(4);
    pkt_data = acc_now << (SW'(ACC_W) - all_bits);
    pkt_bits = BW'(all_bits);
    pol_sh   = acc_now << (SW'(ACC_W) - pol_bits);
    pol_map  = pol_sh[ACC_W-1 -: POL_W];
  end

endmodule

// File: rtl/pong_tx.sv
module pong_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [9:0] tag,
  input  logic       tx_ready,
  output logic [7:0] tx_data,
  output logic       tx_valid,
  output logic       busy
);

  typedef enum logic [1:0] {PG_IDLE, PG_HI, PG_LO} pong_st_e;

  pong_st_e   st_q, st_d;
  logic [9:0] tag_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PG_IDLE: if (load)     st_d = PG_HI;
      PG_HI:   if (tx_ready) st_d = PG_LO;
      PG_LO:   if (tx_ready) st_d = PG_IDLE;
      default:               st_d = PG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PG_IDLE;
      tag_q <= '0;
    end else begin
      st_q <= st_d;
      if (load && st_q == PG_IDLE) tag_q <= tag;
    end
  end

  always_comb begin
    busy     = (st_q != PG_IDLE);
    tx_valid = busy;
    tx_data  = (st_q == PG_LO) ? {1'b0, tag_q[6:0]}
                               : {1'b1, 4'b0001, tag_q[2+7:7]};
  end

  // R5
  pong_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R6
  pong_load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);

endmodule

// File: rtl/cmdstream_decoder.sv
module cmdstream_decoder
  import cmd_pkg::*;
#(
  parameter int MAX_BYTES = 15,
  parameter int POL_W     = 17,
  localparam int ACC_W = 7 * MAX_BYTES,
  localparam int CW    = $clog2(MAX_BYTES + 1),
  localparam int BW    = $clog2(ACC_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       rx_data,
  input  logic             rx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_valid,
  output logic             pwr_on,
  output logic             pwr_off,
  output logic             panic_ack,
  output logic             host_link_err,
  output logic             point_fire,
  output logic [9:0]       point_target,
  output logic             ping_seen,
  output logic [9:0]       ping_tag,
  output logic             pol_set,
  output logic [POL_W-1:0] pol_map,
  output logic             pkt_valid,
  output logic [ACC_W-1:0] pkt_data,
  output logic [BW-1:0]    pkt_bits,
  output logic             proto_err
);

  // Reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic             msg_end, ovf_now, pong_busy, pong_load;
  logic [7:0]       first_now;
  logic [CW-1:0]    n_now;
  logic [ACC_W-1:0] acc_now, pkt_data_c;
  logic [9:0]       value10;
  logic [POL_W-1:0] pol_map_c;
  logic [BW-1:0]    pkt_bits_c;
  msg_kind_e        kind, kind_eff;

  cmd_framer #(.MAX_BYTES(MAX_BYTES)) u_framer (
    .clk(clk), .rst_n(rst_sync_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .msg_end(msg_end), .first_now(first_now), .n_now(n_now),
    .acc_now(acc_now), .ovf_now(ovf_now)
  );

  cmd_classify #(.MAX_BYTES(MAX_BYTES), .POL_W(POL_W)) u_classify (
    .first_now(first_now), .n_now(n_now), .acc_now(acc_now), .ovf_now(ovf_now),
    .kind(kind), .value10(value10), .pol_map(pol_map_c),
    .pkt_data(pkt_data_c), .pkt_bits(pkt_bits_c)
  );

  always_comb begin
    kind_eff = K_NONE;
    if (msg_end) kind_eff = (kind == K_PING && pong_busy) ? K_ERR : kind;
    pong_load = (kind_eff == K_PING);
  end

  pong_tx u_pong (
    .clk(clk), .rst_n(rst_sync_n), .load(pong_load), .tag(value10),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_valid(tx_valid), .busy(pong_busy)
  );

  // Output registers: pulses every cycle, fields behind their own enables
  logic [8:0] pulse_d;
  always_comb begin
    pulse_d = '0;
    unique case (kind_eff)
      K_ON:    pulse_d[8] = 1'b1;
      K_OFF:   pulse_d[7] = 1'b1;
      K_ACK:   pulse_d[6] = 1'b1;
      K_SERR:  pulse_d[5] = 1'b1;
      K_POINT: pulse_d[4] = 1'b1;
      K_PING:  pulse_d[3] = 1'b1;
      K_POL:   pulse_d[2] = 1'b1;
      K_PKT:   pulse_d[1] = 1'b1;
      K_ERR:   pulse_d[0] = 1'b1;
      default: pulse_d    = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      {pwr_on, pwr_off, panic_ack, host_link_err, point_fire,
       ping_seen, pol_set, pkt_valid, proto_err} <= '0;
      point_target <= '0;
      ping_tag     <= '0;
      pol_map      <= '0;
      pkt_data     <= '0;
      pkt_bits     <= '0;
    end else begin
      {pwr_on, pwr_off, panic_ack, host_link_err, point_fire,
       ping_seen, pol_set, pkt_valid, proto_err} <= pulse_d;
      if (pulse_d[4]) point_target <= value10;
      if (pulse_d[3]) ping_tag     <= value10;
      if (pulse_d[2]) pol_map      <= pol_map_c;
      if (pulse_d[1]) begin
        pkt_data <= pkt_data_c;
        pkt_bits <= pkt_bits_c;
      end
    end
  end

  // R11
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({pwr_on, pwr_off, panic_ack, host_link_err, point_fire,
              ping_seen, pol_set, pkt_valid, proto_err}));

  // R1
  pulse_after_end_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pwr_on || pwr_off || panic_ack || host_link_err || point_fire ||
     ping_seen || pol_set || pkt_valid || proto_err)
    |-> $past(rx_valid && !rx_data[7]));

  // R6
  ping_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ping_seen |-> !$past(tx_valid));

  // R8
  pkt_len_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pkt_valid |-> (pkt_bits >= BW'(14) && pkt_bits <= BW'(ACC_W)));

  // R11
  target_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !point_fire |-> $stable(point_target));

endmodule

// File: tb/cmdstream_decoder_tb.sv
`timescale 1ns/1ps
module cmdstream_decoder_tb;

  localparam int MAXB  = 4;
  localparam int POLW  = 12;
  localparam int ACCW  = 7 * MAXB;
  localparam int BWB   = $clog2(ACCW + 1);

  logic            clk = 1'b0;
  logic            rst_n;
  logic [7:0]      rx_data;
  logic            rx_valid;
  logic            tx_ready;
  logic [7:0]      tx_data;
  logic            tx_valid;
  logic            pwr_on, pwr_off, panic_ack, host_link_err, point_fire;
  logic            ping_seen, pol_set, pkt_valid, proto_err;
  logic [9:0]      point_target, ping_tag;
  logic [POLW-1:0] pol_map;
  logic [ACCW-1:0] pkt_data;
  logic [BWB-1:0]  pkt_bits;

  always #4 clk = ~clk;

  cmdstream_decoder #(.MAX_BYTES(MAXB), .POL_W(POLW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_valid(tx_valid),
    .pwr_on(pwr_on), .pwr_off(pwr_off), .panic_ack(panic_ack),
    .host_link_err(host_link_err), .point_fire(point_fire),
    .point_target(point_target), .ping_seen(ping_seen), .ping_tag(ping_tag),
    .pol_set(pol_set), .pol_map(pol_map), .pkt_valid(pkt_valid),
    .pkt_data(pkt_data), .pkt_bits(pkt_bits), .proto_err(proto_err)
  );

  // Pulse bit positions: 8 on, 7 off, 6 ack, 5 link, 4 point, 3 ping, 2 pol, 1 pkt, 0 err
  localparam logic [8:0] P_ON = 9'h100, P_OFF = 9'h080, P_ACK = 9'h040,
                         P_SERR = 9'h020, P_POINT = 9'h010, P_PING = 9'h008,
                         P_POL = 9'h004, P_PKT = 9'h002, P_ERR = 9'h001;
  logic [8:0] pulses;
  assign pulses = {pwr_on, pwr_off, panic_ack, host_link_err, point_fire,
                   ping_seen, pol_set, pkt_valid, proto_err};

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] mb [0:7];
  logic [7:0] txlog [0:255];
  int txn = 0;

  always @(negedge clk) begin
    if (tx_valid && tx_ready) begin
      txlog[txn % 256] = tx_data;
      txn = txn + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Sends mb[0..n-1]; returns at the falling edge where the result is visible
  task automatic send_msg(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      rx_data  = mb[i];
      rx_valid = 1'b1;
    end
    @(posedge clk); #1;
    rx_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [63:0] bits_of(input int n, input int first_bits);
    logic [63:0] a;
    a = (first_bits == 3) ? 64'(mb[0][2:0]) : 64'(mb[0][6:0]);
    for (int i = 1; i < n; i++) a = (a << 7) | 64'(mb[i][6:0]);
    return a;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_valid = 1'b0; rx_data = '0; tx_ready = 1'b1;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    @(negedge clk);
    // R12
    chk("R12 pulses", 64'(pulses), 0);
    chk("R12 tx_valid", 64'(tx_valid), 0);
    chk("R12 fields", 64'({point_target, ping_tag, pol_map}), 0);
    chk("R12 pkt", 64'({pkt_data, pkt_bits}), 0);

    // R2: sweep every single-byte message
    for (int b = 0; b < 128; b++) begin
      logic [8:0] e;
      mb[0] = 8'(b);
      send_msg(1);
      e = (b == 8'h21) ? P_ON : (b == 8'h20) ? P_OFF :
          (b == 8'h00) ? P_ACK : (b == 8'h01) ? P_SERR : P_ERR;
      chk("R2 single byte", 64'(pulses), 64'(e));
    end
    // R11: pulse lasts a single cycle
    mb[0] = 8'h21; send_msg(1);
    @(negedge clk);
    chk("R11 one cycle", 64'(pulses), 0);

    // R3: all point targets
    for (int t = 0; t < 1024; t++) begin
      logic [9:0] tv;
      tv = 10'(t);
      mb[0] = {5'b10100, tv[9:7]};
      mb[1] = {1'b0, tv[6:0]};
      send_msg(2);
      chk("R3 point pulse", 64'(pulses), 64'(P_POINT));
      chk("R3 point target", 64'(point_target), 64'(tv));
    end
    // R11: fields hold across other commands
    mb[0] = 8'h20; send_msg(1);
    chk("R11 target hold", 64'(point_target), 64'h3FF);

    // R10: sweep every multi-byte first byte, two-byte message
    for (int f = 128; f < 256; f++) begin
      logic [7:0] fb;
      logic [8:0] e;
      fb = 8'(f);
      mb[0] = fb; mb[1] = 8'h2A;
      send_msg(2);
      if (fb == 8'hFF) e = P_PKT;
      else if (fb[6:3] == 4'b0100) e = P_POINT;
      else if (fb[6:3] == 4'b0001) e = P_PING;
      else if (fb[6:3] == 4'b0010) e = P_POL;
      else e = P_ERR;
      chk("R10 first byte", 64'(pulses), 64'(e));
      idle(4);
    end

    // R4 R5: ping tags and pong bytes
    for (int k = 0; k < 5; k++) begin
      logic [9:0] tg;
      int base;
      tg = (k == 0) ? 10'h000 : (k == 1) ? 10'h001 : (k == 2) ? 10'h3FF :
           (k == 3) ? 10'h155 : 10'h2AA;
      mb[0] = {5'b10001, tg[9:7]}; mb[1] = {1'b0, tg[6:0]};
      base = txn;
      send_msg(2);
      chk("R4 ping pulse", 64'(pulses), 64'(P_PING));
      chk("R4 ping tag", 64'(ping_tag), 64'(tg));
      idle(4);
      chk("R5 pong count", 64'(txn - base), 2);
      chk("R5 pong hi", 64'(txlog[base % 256]), 64'({5'b10001, tg[9:7]}));
      chk("R5 pong lo", 64'(txlog[(base + 1) % 256]), 64'({1'b0, tg[6:0]}));
    end

    // R5 R6: stall, then a second ping while the pong is pending
    begin
      int base;
      tx_ready = 1'b0;
      base = txn;
      mb[0] = 8'h8D; mb[1] = 8'h45;
      send_msg(2);
      chk("R5 tx_valid", 64'(tx_valid), 1);
      idle(3);
      @(negedge clk);
      chk("R5 stall hold", 64'(tx_data), 64'h8D);
      mb[0] = 8'h8A; mb[1] = 8'h11;
      send_msg(2);
      chk("R6 busy ping err", 64'(pulses), 64'(P_ERR));
      chk("R6 tag kept", 64'(ping_tag), 64'h2C5);
      tx_ready = 1'b1;
      idle(6);
      chk("R6 pong count", 64'(txn - base), 2);
      chk("R6 pong hi", 64'(txlog[base % 256]), 64'h8D);
      chk("R6 pong lo", 64'(txlog[(base + 1) % 256]), 64'h45);
    end

    // R7: polarity lengths 2..4 over several patterns
    for (int n = 2; n <= MAXB; n++) begin
      for (int s = 0; s < 6; s++) begin
        logic [63:0] a, e;
        int nb;
        mb[0] = {5'b10010, 3'(s * 5 + n)};
        for (int i = 1; i < n; i++)
          mb[i] = {(i < n - 1), 7'(s * 37 + i * 91 + n)};
        send_msg(n);
        a  = bits_of(n, 3);
        nb = 7 * n - 4;
        e  = (nb >= POLW) ? (a >> (nb - POLW)) : (a << (POLW - nb));
        chk("R7 pol pulse", 64'(pulses), 64'(P_POL));
        chk("R7 pol map", 64'(pol_map), e & ((64'd1 << POLW) - 1));
      end
    end

    // R8: packet lengths 2..4
    for (int n = 2; n <= MAXB; n++) begin
      for (int s = 0; s < 4; s++) begin
        logic [63:0] a;
        mb[0] = 8'hFF;
        for (int i = 1; i < n; i++)
          mb[i] = {(i < n - 1), 7'(s * 53 + i * 29)};
        send_msg(n);
        a = bits_of(n, 7);
        chk("R8 pkt pulse", 64'(pulses), 64'(P_PKT));
        chk("R8 pkt data", 64'(pkt_data), a << (ACCW - 7 * n));
        chk("R8 pkt bits", 64'(pkt_bits), 64'(7 * n));
      end
    end

    // R9: length errors
    mb[0] = 8'hA5; mb[1] = 8'h85; mb[2] = 8'h01;
    send_msg(3);
    chk("R9 long point", 64'(pulses), 64'(P_ERR));
    mb[0] = 8'h89; mb[1] = 8'h85; mb[2] = 8'h01;
    send_msg(3);
    chk("R9 long ping", 64'(pulses), 64'(P_ERR));
    chk("R9 no pong", 64'(tx_valid), 0);
    mb[0] = 8'h93; mb[1] = 8'hFF; mb[2] = 8'h81; mb[3] = 8'h82; mb[4] = 8'h03;
    send_msg(5);
    chk("R9 long pol", 64'(pulses), 64'(P_ERR));
    mb[0] = 8'hFF; mb[1] = 8'hFF; mb[2] = 8'h81; mb[3] = 8'h82; mb[4] = 8'h03;
    send_msg(5);
    chk("R9 long pkt", 64'(pulses), 64'(P_ERR));
    chk("R9 pkt bits kept", 64'(pkt_bits), 64'(7 * MAXB));
    // R1: framing recovers after a discarded message
    mb[0] = 8'h21; send_msg(1);
    chk("R1 recover", 64'(pulses), 64'(P_ON));

    idle(2);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule